// File: doc/BRIEF.md
# SCSI Initiator Phase Sequencer

This block steers one initiator-side SCSI transaction through its whole life. The transaction starts with selection and ends with the final disconnect. A start strobe gives the target ID, the transfer direction and whether the attempt is only a presence probe. The block answers with a select command and moves into its selecting state.

After that, each time the bus controller reports an event, the block takes one snapshot of the controller:

- the DMA error flag
- the parity and gross error flags
- the current bus phase
- the sequence-step value
- the interrupt-cause bits
- the FIFO byte count and the two bytes at the head of the FIFO
- whether any bytes remain to be moved

From that snapshot and its own state, the block issues at most one controller command and reports one outcome code. Both appear one clock after the event.

Errors are judged first, on a fixed priority ladder that separates error outcomes from reset outcomes. If the snapshot passes that ladder, the current state checks what it expected. The reported bus phase then chooses the next step. Every terminal outcome (done, error or reset) sends the machine back to idle. An event that arrives while idle is reported as stray.

Top module: `scsi_phase_seq`

## Requirements
- R1: After synchronous reset, `state_o` is 0 (idle), `cmd_valid`, `res_valid` and `target_absent` are 0.
- R2: A `start` pulse while idle gives, one cycle later, `cmd_valid`=1 with `cmd_op`=2 (select), `cmd_load_cdb`=1 and `cmd_target` equal to the start target, and `state_o`=1 (selecting). A `start` pulse while not idle has no effect: no command and no state change.
- R3: An event while idle gives `res_valid`=1 with `res_code`=6 (stray), no command, and the state stays idle.
- R4: The error ladder runs in this order of precedence:
  - A DMA error gives code 3 (error).
  - Next, a gross error together with the disconnect cause (bit 2), in the selecting state of a probe, sets `target_absent` and gives code 4 (reset).
  - Next, a parity error gives code 4.
  - Next, any of cause bits 3 to 7 (bus reset, illegal command, reselected, selected with attention, selected as target) gives code 3.
- R5: The disconnect cause handles three cases:
  - In state 7 (awaiting final disconnect), it gives code 2 (done).
  - In the selecting state of a probe, it sets `target_absent` and gives code 4.
  - In any other state, it issues `cmd_op`=1 (flush FIFO) and gives code 3.
- R6: In the selecting state, the event needs both service (cause bit 1) and complete (cause bit 0), or the code is 4. A step of 4 (done) sets `cmd_sent` and proceeds to phase dispatch. Steps 2 and 3 proceed to phase dispatch with `cmd_flush`=1 when the FIFO count is nonzero. Any other step gives code 4.
- R7: In state 5 (status), the cause must be complete without service, and the FIFO count must be at least 2. Otherwise the code is 4. On success, `status_byte` takes the first byte and `msg_byte` the second, `cmd_op`=6 (message accept) is issued, the code is 0 (continue), and the state becomes 7.
- R8: The data phases are dispatched as follows:
  - Phase 0 (data out) with direction read gives code 4.
  - Phase 1 (data in) with direction write gives code 4.
  - Either data phase with `rem_zero`=1 gives code 4.
  - Otherwise `cmd_op`=4 (DMA transfer) is issued, the code is 1 (I/O), and the state becomes 4 (data out) or 3 (data in).
- R9: Phase 2 (command) issues `cmd_op`=3 (transfer info) with `cmd_load_cdb`=1 and moves to state 2 (awaiting service). In state 2, a nonzero FIFO count sets `cmd_flush` on the next command; an empty FIFO sets `cmd_sent`.
- R10: Phase 3 (status) issues `cmd_op`=5 (initiator complete) and enters state 5. Phase 7 (message in) issues `cmd_op`=6 and enters state 6. Phases 4, 5 and 6 give code 4.
- R11: Every code 2, 3 or 4 returns the state to idle. Any event without disconnect in state 7 gives code 4.
- R12: In the data-in, data-out and message-in states, an event without the service cause gives code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (only honoured while idle) |
| start_target | input | 3 | Target ID for the selection |
| start_read | input | 1 | 1 = data flows from target (read), 0 = write |
| start_probe | input | 1 | 1 = presence probe |
| rem_zero | input | 1 | No bytes remain to transfer |
| ev_valid | input | 1 | Controller event snapshot is valid |
| ev_dma_err | input | 1 | DMA error flag |
| ev_parity_err | input | 1 | Parity error flag |
| ev_gross_err | input | 1 | Gross error flag |
| ev_cause | input | 8 | Interrupt causes: 0 complete, 1 service, 2 disconnect, 3 bus reset, 4 illegal command, 5 reselected, 6 selected with attention, 7 selected as target |
| ev_step | input | 3 | Sequence-step value |
| ev_phase | input | 3 | Bus phase |
| ev_fifo_cnt | input | 5 | FIFO byte count |
| ev_byte0 | input | 8 | FIFO head byte |
| ev_byte1 | input | 8 | FIFO second byte |
| cmd_valid | output | 1 | Command strobe |
| cmd_op | output | 3 | Command opcode |
| cmd_flush | output | 1 | Flush FIFO before the command |
| cmd_load_cdb | output | 1 | Load command bytes into FIFO before the command |
| cmd_target | output | 3 | Target of the transaction |
| res_valid | output | 1 | Outcome strobe |
| res_code | output | 3 | Outcome code |
| status_byte | output | 8 | Captured status byte |
| msg_byte | output | 8 | Captured message byte |
| target_absent | output | 1 | Probe found no target |
| cmd_sent | output | 1 | Command bytes known to have gone out |
| state_o | output | 3 | Current state |

## Verification
The main sweep drives selecting-state events with every combination of the following:

- all 256 cause patterns
- DMA error, parity error and gross error flags
- the probe setting

The bench compares each result with its own model of the priority ladder. The sweep shows whether each error class outranks the one below it, and it separates the two disconnect branches by the probe setting. Directed sequences walk a full read transaction to done. They also walk every phase dispatch, the direction and zero-count checks, the step values 2, 4 and 5, and the status-state byte-count limit. Further sequences cover a stray idle event and a start issued while busy. Each of these cases tells whether the expected command, flush flag and next state are produced, or whether the transaction is refused with a reset.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;
    localparam int TGT_W   = 3;
    localparam int CAUSE_W = 8;
    localparam int STEP_W  = 3;
    localparam int PHASE_W = 3;
    localparam int CNT_W   = 5;
    localparam int BYTE_W  = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEL, ST_SVC, ST_DIN, ST_DOUT, ST_STAT, ST_MSGI, ST_FINAL
    } seq_state_t;

    typedef enum logic [2:0] {
        RC_CONT, RC_IO, RC_DONE, RC_ERROR, RC_RESET, RC_QUICK, RC_STRAY
    } res_code_t;

    typedef enum logic [2:0] {
        OP_NOP, OP_FLUSH, OP_SELECT, OP_XFER, OP_DMA_XFER, OP_INIT_COMP, OP_MSG_ACC
    } op_t;

    localparam int C_CMP = 0;
    localparam int C_SVC = 1;
    localparam int C_DSC = 2;
    localparam int C_FIRST_FATAL = 3;

    localparam logic [PHASE_W-1:0] PH_DOUT = 3'd0;
    localparam logic [PHASE_W-1:0] PH_DIN  = 3'd1;
    localparam logic [PHASE_W-1:0] PH_CMD  = 3'd2;
    localparam logic [PHASE_W-1:0] PH_STAT = 3'd3;
    localparam logic [PHASE_W-1:0] PH_MIN  = 3'd7;

    localparam logic [STEP_W-1:0] STEP_DONE  = 3'd4;
    localparam logic [STEP_W-1:0] STEP_NOCMD = 3'd2;
    localparam logic [STEP_W-1:0] STEP_PART  = 3'd3;

    localparam logic [CNT_W-1:0] STAT_MIN_BYTES = 5'd2;

    typedef struct packed {
        logic valid;
        op_t  op;
        logic flush;
        logic load_cdb;
    } cmd_t;

    localparam cmd_t CMD_NONE = '{valid: 1'b0, op: OP_NOP, flush: 1'b0, load_cdb: 1'b0};

    function automatic logic is_terminal(res_code_t c);
        return (c == RC_DONE) || (c == RC_ERROR) || (c == RC_RESET);
    endfunction
endpackage

// File: rtl/scsi_err_ladder.sv
module scsi_err_ladder
    import scsi_seq_pkg::*;
(
    input  seq_state_t          state,
    input  logic                probing,
    input  logic                dma_err,
    input  logic                parity_err,
    input  logic                gross_err,
    input  logic [CAUSE_W-1:0]  cause,
    output logic                hit,
    output res_code_t           code,
    output logic                mark_absent,
    output logic                flush
);
    logic dsc, fatal_cause, probe_sel;
    assign dsc         = cause[C_DSC];
    assign fatal_cause = |cause[CAUSE_W-1:C_FIRST_FATAL];
    assign probe_sel   = (state == ST_SEL) && probing;

    always_comb begin
        hit = 1'b1;
        code = RC_ERROR;
        mark_absent = 1'b0;
        flush = 1'b0;
        if (dma_err) begin
            code = RC_ERROR;
        end else if (gross_err && dsc && probe_sel) begin
            code = RC_RESET;
            mark_absent = 1'b1;
        end else if (parity_err) begin
            code = RC_RESET;
        end else if (fatal_cause) begin
            code = RC_ERROR;
        end else if (dsc) begin
            if (state == ST_FINAL) begin
                code = RC_DONE;
            end else if (probe_sel) begin
                code = RC_RESET;
                mark_absent = 1'b1;
            end else begin
                code = RC_ERROR;
                flush = 1'b1;
            end
        end else begin
            hit = 1'b0;
            code = RC_CONT;
        end
    end

    always_comb begin
        if (hit && dma_err) begin
            AST_DMA_FIRST: assert (code == RC_ERROR && !mark_absent); // R4
        end
    end
endmodule

// File: rtl/scsi_phase_dispatch.sv
module scsi_phase_dispatch
    import scsi_seq_pkg::*;
(
    input  logic [PHASE_W-1:0] phase,
    input  logic               dir_read,
    input  logic               rem_zero,
    output logic               ok,
    output res_code_t          code,
    output seq_state_t         nxt,
    output op_t                op,
    output logic               load_cdb
);
    always_comb begin
        ok = 1'b1;
        code = RC_CONT;
        nxt = ST_IDLE;
        op = OP_NOP;
        load_cdb = 1'b0;
        unique case (phase)
            PH_DOUT: begin
                if (dir_read || rem_zero) ok = 1'b0;
                else begin code = RC_IO; nxt = ST_DOUT; op = OP_DMA_XFER; end
            end
            PH_DIN: begin
                if (!dir_read || rem_zero) ok = 1'b0;
                else begin code = RC_IO; nxt = ST_DIN; op = OP_DMA_XFER; end
            end
            PH_CMD: begin
                op = OP_XFER; load_cdb = 1'b1; nxt = ST_SVC;
            end
            PH_STAT: begin
                op = OP_INIT_COMP; nxt = ST_STAT;
            end
            PH_MIN: begin
                op = OP_MSG_ACC; nxt = ST_MSGI;
            end
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/scsi_phase_seq.sv
module scsi_phase_seq
    import scsi_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [TGT_W-1:0]   start_target,
    input  logic               start_read,
    input  logic               start_probe,
    input  logic               rem_zero,
    input  logic               ev_valid,
    input  logic               ev_dma_err,
    input  logic               ev_parity_err,
    input  logic               ev_gross_err,
    input  logic [CAUSE_W-1:0] ev_cause,
    input  logic [STEP_W-1:0]  ev_step,
    input  logic [PHASE_W-1:0] ev_phase,
    input  logic [CNT_W-1:0]   ev_fifo_cnt,
    input  logic [BYTE_W-1:0]  ev_byte0,
    input  logic [BYTE_W-1:0]  ev_byte1,
    output logic               cmd_valid,
    output logic [2:0]         cmd_op,
    output logic               cmd_flush,
    output logic               cmd_load_cdb,
    output logic [TGT_W-1:0]   cmd_target,
    output logic               res_valid,
    output logic [2:0]         res_code,
    output logic [BYTE_W-1:0]  status_byte,
    output logic [BYTE_W-1:0]  msg_byte,
    output logic               target_absent,
    output logic               cmd_sent,
    output logic [2:0]         state_o
);
    seq_state_t state_q, state_n;
    cmd_t       cmd_q, cmd_n;
    res_code_t  rc_q, rc_n;
    logic       rv_q, rv_n;
    logic       sent_q, sent_n, absent_q, absent_n;
    logic       dir_q, probe_q, capture;
    logic [TGT_W-1:0]  tgt_q;
    logic [BYTE_W-1:0] stat_q, msg_q;

    logic      err_hit, err_absent, err_flush;
    res_code_t err_code;
    logic      dsp_ok, dsp_load;
    res_code_t dsp_code;
    seq_state_t dsp_state;
    op_t       dsp_op;

    scsi_err_ladder u_ladder (
        .state(state_q), .probing(probe_q), .dma_err(ev_dma_err),
        .parity_err(ev_parity_err), .gross_err(ev_gross_err), .cause(ev_cause),
        .hit(err_hit), .code(err_code), .mark_absent(err_absent), .flush(err_flush)
    );

    scsi_phase_dispatch u_dispatch (
        .phase(ev_phase), .dir_read(dir_q), .rem_zero(rem_zero),
        .ok(dsp_ok), .code(dsp_code), .nxt(dsp_state), .op(dsp_op), .load_cdb(dsp_load)
    );

    logic svc, cmp, fifo_any, do_disp, pre_flush, go_reset;
    assign svc      = ev_cause[C_SVC];
    assign cmp      = ev_cause[C_CMP];
    assign fifo_any = (ev_fifo_cnt != '0);

    always_comb begin
        state_n = state_q;
        cmd_n = CMD_NONE;
        rv_n = 1'b0;
        rc_n = RC_CONT;
        sent_n = sent_q;
        absent_n = absent_q;
        capture = 1'b0;
        do_disp = 1'b0;
        pre_flush = 1'b0;
        go_reset = 1'b0;
        if (ev_valid) begin
            if (state_q == ST_IDLE) begin
                rv_n = 1'b1;
                rc_n = RC_STRAY;
            end else if (err_hit) begin
                rv_n = 1'b1;
                rc_n = err_code;
                state_n = ST_IDLE;
                absent_n = absent_q | err_absent;
                if (err_flush) cmd_n = '{valid: 1'b1, op: OP_FLUSH, flush: 1'b0, load_cdb: 1'b0};
            end else begin
                unique case (state_q)
                    ST_SEL: begin
                        if (!(svc && cmp)) go_reset = 1'b1;
                        else if (ev_step == STEP_DONE) begin sent_n = 1'b1; do_disp = 1'b1; end
                        else if (ev_step == STEP_NOCMD || ev_step == STEP_PART) begin
                            pre_flush = fifo_any; do_disp = 1'b1;
                        end else go_reset = 1'b1;
                    end
                    ST_SVC: begin
                        if (fifo_any) pre_flush = 1'b1;
                        else sent_n = 1'b1;
                        do_disp = 1'b1;
                    end
                    ST_DIN, ST_MSGI: begin
                        if (!svc) go_reset = 1'b1;
                        else do_disp = 1'b1;
                    end
                    ST_DOUT: begin
                        if (!svc) go_reset = 1'b1;
                        else begin pre_flush = fifo_any; do_disp = 1'b1; end
                    end
                    ST_STAT: begin
                        if (svc || !cmp || ev_fifo_cnt < STAT_MIN_BYTES) go_reset = 1'b1;
                        else begin
                            capture = 1'b1;
                            cmd_n = '{valid: 1'b1, op: OP_MSG_ACC, flush: 1'b0, load_cdb: 1'b0};
                            state_n = ST_FINAL;
                            rv_n = 1'b1;
                            rc_n = RC_CONT;
                        end
                    end
                    default: go_reset = 1'b1;
                endcase
                if (do_disp) begin
                    if (!dsp_ok) go_reset = 1'b1;
                    else begin
                        rv_n = 1'b1;
                        rc_n = dsp_code;
                        state_n = dsp_state;
                        cmd_n = '{valid: 1'b1, op: dsp_op, flush: pre_flush, load_cdb: dsp_load};
                    end
                end
                if (go_reset) begin
                    rv_n = 1'b1;
                    rc_n = RC_RESET;
                    state_n = ST_IDLE;
                    cmd_n = CMD_NONE;
                end
            end
        end
        if (start && state_q == ST_IDLE) begin
            state_n = ST_SEL;
            cmd_n = '{valid: 1'b1, op: OP_SELECT, flush: 1'b0, load_cdb: 1'b1};
            sent_n = 1'b0;
            absent_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cmd_q    <= CMD_NONE;
            rv_q     <= 1'b0;
            rc_q     <= RC_CONT;
            sent_q   <= 1'b0;
            absent_q <= 1'b0;
            dir_q    <= 1'b0;
            probe_q  <= 1'b0;
            tgt_q    <= '0;
            stat_q   <= '0;
            msg_q    <= '0;
        end else begin
            state_q  <= state_n;
            cmd_q    <= cmd_n;
            rv_q     <= rv_n;
            rc_q     <= rc_n;
            sent_q   <= sent_n;
            absent_q <= absent_n;
            if (start && state_q == ST_IDLE) begin
                dir_q   <= start_read;
                probe_q <= start_probe;
                tgt_q   <= start_target;
            end
            if (capture) begin
                stat_q <= ev_byte0;
                msg_q  <= ev_byte1;
            end
        end
    end

    assign cmd_valid     = cmd_q.valid;
    assign cmd_op        = cmd_q.op;
    assign cmd_flush     = cmd_q.flush;
    assign cmd_load_cdb  = cmd_q.load_cdb;
    assign cmd_target    = tgt_q;
    assign res_valid     = rv_q;
    assign res_code      = rc_q;
    assign status_byte   = stat_q;
    assign msg_byte      = msg_q;
    assign target_absent = absent_q;
    assign cmd_sent      = sent_q;
    assign state_o       = state_q;

    AST_TERMINAL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (rv_q && is_terminal(rc_q)) |-> (state_q == ST_IDLE)); // R11
    AST_STRAY_REPORT: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && state_q == ST_IDLE) |=> (rv_q && rc_q == RC_STRAY)); // R3
    AST_IO_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        (rv_q && rc_q == RC_IO) |-> (state_q == ST_DIN || state_q == ST_DOUT)); // R8
    AST_FINAL_FROM_STAT: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !err_hit && state_q == ST_STAT && state_n == ST_FINAL) |=> (cmd_q.op == OP_MSG_ACC)); // R7
    AST_SELECT_ENTERS_SEL: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.valid && cmd_q.op == OP_SELECT) |-> (state_q == ST_SEL)); // R2
endmodule

// File: tb/scsi_phase_seq_tb.sv
`timescale 1ns/100ps
module scsi_phase_seq_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, start_read = 0, start_probe = 0, rem_zero = 0;
    logic [2:0] start_target = 0;
    logic ev_valid = 0, ev_dma_err = 0, ev_parity_err = 0, ev_gross_err = 0;
    logic [7:0] ev_cause = 0;
    logic [2:0] ev_step = 0, ev_phase = 0;
    logic [4:0] ev_fifo_cnt = 0;
    logic [7:0] ev_byte0 = 0, ev_byte1 = 0;
    logic cmd_valid, cmd_flush, cmd_load_cdb, res_valid, target_absent, cmd_sent;
    logic [2:0] cmd_op, cmd_target, res_code, state_o;
    logic [7:0] status_byte, msg_byte;

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    scsi_phase_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .start_target(start_target),
        .start_read(start_read), .start_probe(start_probe), .rem_zero(rem_zero),
        .ev_valid(ev_valid), .ev_dma_err(ev_dma_err), .ev_parity_err(ev_parity_err),
        .ev_gross_err(ev_gross_err), .ev_cause(ev_cause), .ev_step(ev_step),
        .ev_phase(ev_phase), .ev_fifo_cnt(ev_fifo_cnt), .ev_byte0(ev_byte0),
        .ev_byte1(ev_byte1), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_flush(cmd_flush), .cmd_load_cdb(cmd_load_cdb), .cmd_target(cmd_target),
        .res_valid(res_valid), .res_code(res_code), .status_byte(status_byte),
        .msg_byte(msg_byte), .target_absent(target_absent), .cmd_sent(cmd_sent),
        .state_o(state_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_start(input logic [2:0] tgt, input logic rd, input logic probe);
        @(negedge clk);
        start = 1'b1; start_target = tgt; start_read = rd; start_probe = probe;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic set_ev(input logic [7:0] cause, input logic [2:0] step,
                          input logic [2:0] phase, input logic [4:0] fifo);
        ev_dma_err = 0; ev_parity_err = 0; ev_gross_err = 0;
        ev_cause = cause; ev_step = step; ev_phase = phase; ev_fifo_cnt = fifo;
    endtask

    task automatic pulse_ev();
        @(negedge clk); ev_valid = 1'b1;
        @(negedge clk); ev_valid = 1'b0;
    endtask

    task automatic ev(input logic [7:0] cause, input logic [2:0] step,
                      input logic [2:0] phase, input logic [4:0] fifo);
        set_ev(cause, step, phase, fifo);
        pulse_ev();
    endtask

    task automatic check_out(input string req, input int code, input int cv,
                             input int op, input int st);
        chk(req, res_valid, 1);
        chk(req, res_code, code);
        chk(req, cmd_valid, cv);
        if (cv != 0) chk(req, cmd_op, op);
        chk(req, state_o, st);
    endtask

    initial begin
        #(180000 * 5);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 state", state_o, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 res_valid", res_valid, 0);
        chk("R1 absent", target_absent, 0);

        // R3 stray event while idle
        ev(8'h03, 3'd4, 3'd3, 5'd0);
        chk("R3 res_valid", res_valid, 1);
        chk("R3 code", res_code, 6);
        chk("R3 cmd", cmd_valid, 0);
        chk("R3 state", state_o, 0);

        // R2 start and busy start
        do_start(3'd5, 1'b1, 1'b0);
        chk("R2 cmd_valid", cmd_valid, 1);
        chk("R2 op", cmd_op, 2);
        chk("R2 load", cmd_load_cdb, 1);
        chk("R2 target", cmd_target, 5);
        chk("R2 state", state_o, 1);
        do_start(3'd2, 1'b0, 1'b0);
        chk("R2 busy no cmd", cmd_valid, 0);
        chk("R2 busy state", state_o, 1);
        chk("R2 busy target", cmd_target, 5);

        // Full read: R6 step done, R8 data in, R12, R10 status, R7, R5 done
        rem_zero = 0;
        ev(8'h03, 3'd4, 3'd1, 5'd0);
        check_out("R8 data-in", 1, 1, 4, 3);
        chk("R6 sent", cmd_sent, 1);
        ev(8'h02, 3'd0, 3'd3, 5'd0);
        check_out("R10 status phase", 0, 1, 5, 5);
        ev_byte0 = 8'h02; ev_byte1 = 8'h00;
        ev(8'h01, 3'd0, 3'd7, 5'd2);
        check_out("R7 status bytes", 0, 1, 6, 7);
        chk("R7 status_byte", status_byte, 8'h02);
        chk("R7 msg_byte", msg_byte, 8'h00);
        ev(8'h04, 3'd0, 3'd0, 5'd0);
        check_out("R5 final done", 2, 0, 0, 0);

        // Near-exhaustive ladder sweep in selecting state: R4 R5 R6
        for (int v = 0; v < 8192; v++) begin
            logic [7:0] cs;
            logic dma, par, gro, prb;
            int ecode, ecv, eop, est, eabs;
            cs = v[7:0]; dma = v[8]; par = v[9]; gro = v[10]; prb = v[11];
            if (v[12]) continue;
            ecv = 0; eop = 0; est = 0; eabs = 0;
            if (dma) ecode = 3;
            else if (gro && cs[2] && prb) begin ecode = 4; eabs = 1; end
            else if (par) ecode = 4;
            else if (cs[7:3] != 0) ecode = 3;
            else if (cs[2]) begin
                if (prb) begin ecode = 4; eabs = 1; end
                else begin ecode = 3; ecv = 1; eop = 1; end
            end
            else if (cs[1:0] != 2'b11) ecode = 4;
            else begin ecode = 0; ecv = 1; eop = 5; est = 5; end
            do_reset();
            do_start(3'd1, 1'b0, prb);
            set_ev(cs, 3'd4, 3'd3, 5'd0);
            ev_dma_err = dma; ev_parity_err = par; ev_gross_err = gro;
            pulse_ev();
            check_out("R4 ladder sweep", ecode, ecv, eop, est);
            chk("R5 absent sweep", target_absent, eabs);
        end

        // R8 direction and remaining-count refusals
        do_reset(); do_start(3'd0, 1'b0, 1'b0);
        ev(8'h03, 3'd4, 3'd1, 5'd0);
        check_out("R8 data-in on write", 4, 0, 0, 0);
        do_reset(); do_start(3'd0, 1'b1, 1'b0);
        ev(8'h03, 3'd4, 3'd0, 5'd0);
        check_out("R8 data-out on read", 4, 0, 0, 0);
        do_reset(); do_start(3'd0, 1'b0, 1'b0);
        rem_zero = 1;
        ev(8'h03, 3'd4, 3'd0, 5'd0);
        check_out("R8 zero remaining", 4, 0, 0, 0);
        rem_zero = 0;

        // R6 step 2 with FIFO bytes, R9 command phase and service state flush
        do_reset(); do_start(3'd0, 1'b0, 1'b0);
        ev(8'h03, 3'd2, 3'd2, 5'd2);
        check_out("R9 command phase", 0, 1, 3, 2);
        chk("R6 step2 flush", cmd_flush, 1);
        chk("R9 load_cdb", cmd_load_cdb, 1);
        chk("R6 step2 not sent", cmd_sent, 0);
        ev(8'h02, 3'd0, 3'd0, 5'd3);
        check_out("R8 data-out", 1, 1, 4, 4);
        chk("R9 svc flush", cmd_flush, 1);
        chk("R9 svc not sent", cmd_sent, 0);
        // R12 data-out without service
        ev(8'h01, 3'd0, 3'd3, 5'd0);
        check_out("R12 no service", 4, 0, 0, 0);

        // R9 service state with empty FIFO sets sent
        do_reset(); do_start(3'd0, 1'b1, 1'b0);
        ev(8'h03, 3'd3, 3'd2, 5'd0);
        chk("R6 step3 no flush", cmd_flush, 0);
        ev(8'h02, 3'd0, 3'd7, 5'd0);
        check_out("R10 msg-in", 0, 1, 6, 6);
        chk("R9 sent", cmd_sent, 1);
        // R5 disconnect elsewhere flushes
        ev(8'h04, 3'd0, 3'd0, 5'd0);
        check_out("R5 flush on disconnect", 3, 1, 1, 0);

        // R6 bad step
        do_reset(); do_start(3'd0, 1'b1, 1'b0);
        ev(8'h03, 3'd5, 3'd3, 5'd0);
        check_out("R6 bad step", 4, 0, 0, 0);

        // R10 message-out phase refused
        do_reset(); do_start(3'd0, 1'b1, 1'b0);
        ev(8'h03, 3'd4, 3'd6, 5'd0);
        check_out("R10 msg-out refused", 4, 0, 0, 0);

        // R7 short FIFO and bad cause
        do_reset(); do_start(3'd0, 1'b1, 1'b0);
        ev(8'h03, 3'd4, 3'd3, 5'd0);
        ev(8'h01, 3'd0, 3'd7, 5'd1);
        check_out("R7 short fifo", 4, 0, 0, 0);
        do_reset(); do_start(3'd0, 1'b1, 1'b0);
        ev(8'h03, 3'd4, 3'd3, 5'd0);
        ev(8'h03, 3'd0, 3'd7, 5'd2);
        check_out("R7 service set", 4, 0, 0, 0);

        // R11 final state without disconnect
        do_reset(); do_start(3'd0, 1'b1, 1'b0);
        ev(8'h03, 3'd4, 3'd3, 5'd0);
        ev(8'h01, 3'd0, 3'd7, 5'd2);
        ev(8'h02, 3'd0, 3'd7, 5'd0);
        check_out("R11 final no disconnect", 4, 0, 0, 0);

        // R12 data-in without service
        do_reset(); do_start(3'd0, 1'b1, 1'b0);
        ev(8'h03, 3'd4, 3'd1, 5'd0);
        ev(8'h01, 3'd0, 3'd3, 5'd0);
        check_out("R12 data-in no service", 4, 0, 0, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule